// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs single-byte read and write cycles to an external data memory over one 8-bit bus. The same bus lines carry the address and then the data. The 8-bit address comes from an index-register value, so the external space is reached by 8-bit indirect addressing. It adds to the small on-chip data memory, and a bus cycle is started only when an explicit external-access request arrives.

A request carries an address, a direction bit and write data. It is accepted only while the controller is idle. Each cycle then runs through a fixed sequence of phases:

1. The address is driven while an address strobe is high. The address stays driven for one more clock after the strobe falls, so outside logic can latch it on the falling edge.
2. The bus floats for a gap.
3. Either the read strobe or the write strobe goes low.
4. A tail clock follows, in which a one-clock completion pulse is given.

The bus tri-state is controlled through a separate output-enable, output-data and input-data triple.

Top module: `mxbus_master`

## Requirements
- R1: During and right after reset, these outputs hold: `ale`=0, `rd_n`=1, `wr_n`=1, `bus_oe`=0, `done`=0, `req_ready`=1.
- R2: A request is accepted only on a clock edge where `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the accepting edge to the end of the cycle. A `req_valid` given while busy has no effect on the running cycle.
- R3: For ALE_CLKS clocks after acceptance, `ale`=1, `bus_oe`=1 and `bus_out` equals the request address. For one further clock, `ale`=0 while the address is still driven.
- R4: Next, for GAP_CLKS clocks, `bus_oe`=0 with both strobes high.
- R5: Next, for STB_CLKS clocks, exactly one strobe is low: `rd_n` when `req_write`=0, `wr_n` when `req_write`=1. The two strobes are never low together, and neither is low while `ale`=1.
- R6: In a write, `bus_oe`=1 and `bus_out` equals the write data for the whole strobe and for the one clock after `wr_n` returns high.
- R7: In a read, `bus_oe`=0 during the strobe. `rdata` takes the value `bus_in` had in the last strobe clock and shows it while `done`=1.
- R8: `done` is high for exactly one clock, the clock after the strobe ends. `req_ready` returns to 1 on the next clock. A cycle is busy for ALE_CLKS+GAP_CLKS+STB_CLKS+2 clocks.
- R9: While idle, and in the tail clock of a read, `bus_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | External data address |
| req_wdata | input | 8 | Byte to write |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus output enable (0 = high impedance) |
| bus_in | input | 8 | Value seen on the shared bus |
| ale | output | 1 | Address strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read |

## Verification
Every output depends only on the registered phase, so each result is due a fixed number of clocks after the accepting edge:
- the address phase in clocks 1 to ALE_CLKS+1;
- the gap next;
- the strobe in clocks ALE_CLKS+GAP_CLKS+2 to ALE_CLKS+GAP_CLKS+STB_CLKS+1;
- `done` and the read byte in clock ALE_CLKS+GAP_CLKS+STB_CLKS+2.

The bench model counts those clocks from its own accept condition. It compares every output a few nanoseconds after each rising edge, when the registers have settled. A behavioural device in the bench latches the address on the falling edge of `ale` and stores on the rising edge of `wr_n`. A wrong phase order therefore shows up again when the byte is read back.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AHOLD,
        PH_GAP,
        PH_STRB,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic       write;
        logic [7:0] addr;
        logic [7:0] wdata;
    } xreq_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_ADDR:  return PH_AHOLD;
            PH_AHOLD: return PH_GAP;
            PH_GAP:   return PH_STRB;
            PH_STRB:  return PH_TAIL;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
    import mxb_pkg::*;
#(
    parameter int ALE_CLKS = 2,
    parameter int GAP_CLKS = 1,
    parameter int STB_CLKS = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   last
);
    localparam int MAXL = max3(ALE_CLKS, GAP_CLKS, STB_CLKS);
    localparam int CW   = (MAXL < 2) ? 1 : $clog2(MAXL);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;
    phase_e        nxt;

    assign nxt = next_phase(phase);

    always_comb begin
        case (nxt)
            PH_ADDR: reload = CW'(ALE_CLKS - 1);
            PH_GAP:  reload = CW'(GAP_CLKS - 1);
            PH_STRB: reload = CW'(STB_CLKS - 1);
            default: reload = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= PH_ADDR;
                cnt   <= CW'(ALE_CLKS - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            phase <= nxt;
            cnt   <= reload;
        end
    end

    assign last = (phase != PH_IDLE) && (cnt == '0);

    // R8: the tail phase lasts a single clock
    a_r8_tail_single: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |=> (phase == PH_IDLE));

    // R2: leaving idle happens only on a start
    a_r2_start_only: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> $past(start));

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
    import mxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  logic       last,
    input  xreq_t      cur,
    input  logic [7:0] bus_in,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output logic       bus_oe,
    output logic [7:0] bus_out,
    output logic       done,
    output logic [7:0] rdata
);
    logic addr_drv;
    logic data_drv;
    logic strobing;

    assign addr_drv = (phase == PH_ADDR) || (phase == PH_AHOLD);
    assign strobing = (phase == PH_STRB);
    assign data_drv = cur.write && (strobing || phase == PH_TAIL);

    assign ale     = (phase == PH_ADDR);
    assign rd_n    = !(strobing && !cur.write);
    assign wr_n    = !(strobing && cur.write);
    assign bus_oe  = addr_drv || data_drv;
    assign bus_out = addr_drv ? cur.addr : (data_drv ? cur.wdata : 8'h00);
    assign done    = (phase == PH_TAIL);

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (strobing && last && !cur.write)
            rdata <= bus_in;
    end

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r5_no_strobe_in_ale: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    a_r4_float_before_strobe: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(!bus_oe));

    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (bus_oe && $stable(bus_out)));

    a_r6_data_after_wr: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (bus_oe && $stable(bus_out)));

    a_r7_read_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (rdata == $past(bus_in)));

endmodule

// File: rtl/mxbus_master.sv
module mxbus_master
    import mxb_pkg::*;
#(
    parameter int ALE_CLKS = 2,
    parameter int GAP_CLKS = 1,
    parameter int STB_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    input  logic [7:0] bus_in,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output logic       done,
    output logic [7:0] rdata
);
    phase_e phase;
    logic   last;
    logic   accept;
    xreq_t  cur;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (accept)
            cur <= '{write: req_write, addr: req_addr, wdata: req_wdata};
    end

    mxb_seq #(
        .ALE_CLKS(ALE_CLKS),
        .GAP_CLKS(GAP_CLKS),
        .STB_CLKS(STB_CLKS)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .phase(phase),
        .last (last)
    );

    mxb_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .last   (last),
        .cur    (cur),
        .bus_in (bus_in),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .bus_oe (bus_oe),
        .bus_out(bus_out),
        .done   (done),
        .rdata  (rdata)
    );

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    a_r9_idle_float: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_oe);

endmodule

// File: tb/sim_mxbus_master.sv
module sim_mxbus_master;
    localparam int A = 2;
    localparam int G = 1;
    localparam int S = 2;
    localparam int L = A + G + S + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] bus_in;
    logic       ale, rd_n, wr_n, done;
    logic [7:0] rdata;

    always #5 clk = ~clk;

    mxbus_master #(.ALE_CLKS(A), .GAP_CLKS(G), .STB_CLKS(S)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .done(done), .rdata(rdata)
    );

    // behavioural external device: address latch plus byte memory
    logic [7:0] dev_mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] lat = 8'h00;
    initial for (int i = 0; i < 256; i++) begin
        dev_mem[i] = 8'(i * 7 + 3);
        ref_mem[i] = 8'(i * 7 + 3);
    end
    always @(negedge ale) lat = bus_out;
    always @(posedge wr_n) if (!rst) dev_mem[lat] = bus_out;
    assign bus_in = !rd_n ? dev_mem[lat] : 8'hA5;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: k = clocks since acceptance, 0 = idle
    int         k = 0;
    logic       m_w = 1'b0;
    logic [7:0] m_a = 8'h00, m_d = 8'h00;
    always @(posedge clk) begin
        if (rst) k = 0;
        else if (k == 0) begin
            if (req_valid) begin
                k = 1; m_w = req_write; m_a = req_addr; m_d = req_wdata;
            end
        end else if (k == L) begin
            if (m_w) ref_mem[m_a] = m_d;
            k = 0;
        end else k = k + 1;
    end

    always @(posedge clk) begin
        #3;
        begin
            bit in_addr, in_hold, in_gap, in_strb, in_tail;
            bit e_oe;
            string tg;
            in_addr = (k >= 1 && k <= A);
            in_hold = (k == A + 1);
            in_gap  = (k >= A + 2 && k <= A + G + 1);
            in_strb = (k >= A + G + 2 && k <= A + G + S + 1);
            in_tail = (k == L);
            e_oe = in_addr || in_hold || (m_w && (in_strb || in_tail));
            tg = (k == 0) ? (rst ? "R1" : "R9") : in_gap ? "R4" : in_strb ? "R5" :
                 in_tail ? "R8" : "R3";
            chk(req_ready === (k == 0), "R2 ready", {7'd0, req_ready}, {7'd0, k == 0});
            chk(ale === in_addr, tg, {7'd0, ale}, {7'd0, in_addr});
            chk(bus_oe === e_oe, tg, {7'd0, bus_oe}, {7'd0, e_oe});
            chk(rd_n === !(in_strb && !m_w), tg, {7'd0, rd_n}, {7'd0, !(in_strb && !m_w)});
            chk(wr_n === !(in_strb && m_w), tg, {7'd0, wr_n}, {7'd0, !(in_strb && m_w)});
            chk(done === in_tail, tg, {7'd0, done}, {7'd0, in_tail});
            if (in_addr || in_hold)
                chk(bus_out === m_a, "R3 addr", bus_out, m_a);
            if (m_w && (in_strb || in_tail))
                chk(bus_out === m_d, "R6 wdata", bus_out, m_d);
            if (in_tail && !m_w)
                chk(rdata === ref_mem[m_a], "R7 rdata", rdata, ref_mem[m_a]);
        end
    end

    task automatic issue(input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R2: change the inputs while busy; the running cycle must not follow them
        req_write = ~w; req_addr = ~a; req_wdata = ~d;
        req_valid = 1'b0;
    endtask

    task automatic poke_busy(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = !req_ready;
            req_addr  = 8'(i * 13);
            req_write = i[0];
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        issue(1'b1, 8'h10, 8'h3C);
        issue(1'b0, 8'h10, 8'h00);
        issue(1'b1, 8'hFF, 8'h00);
        issue(1'b0, 8'hFF, 8'h55);
        issue(1'b0, 8'h00, 8'h00);
        issue(1'b0, 8'h42, 8'h00);
        poke_busy(2 * L);
        issue(1'b1, 8'h81, 8'hA5);
        issue(1'b1, 8'h7E, 8'h5A);
        issue(1'b0, 8'h81, 8'h00);
        issue(1'b0, 8'h7E, 8'h00);
        for (int t = 0; t < 24; t++)
            issue(t[1], 8'(t * 29 + 5), 8'(t * 91));
        for (int t = 0; t < 24; t++)
            issue(1'b0, 8'(t * 29 + 5), 8'h00);
        repeat (L + 3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule